// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside an 8K-word dual-port memory. It watches the control and address lines of both ports, port A and port B, and keeps one active-low interrupt flag for each port so the two sides can send messages to each other. Each port has a reserved mailbox word at the top of the address space. The upper word, 0x1FFF, is the mailbox that port A writes to reach port B. The word below it, 0x1FFE, is the mailbox that port B writes to reach port A.

A write by the sender to the receiver's mailbox raises the receiver's interrupt. A read of that mailbox by the receiver takes the interrupt down again. The message word sits in the ordinary memory array, which is outside this block, and the block never looks at its value. All port inputs are sampled on the rising clock edge. Each flag is a register, so its output changes one clock after the access cycle.

Top module: `dpram_mailbox_irq`

## Requirements
- R1: While `rst_n` is low at a rising edge, both `a_irq_n` and `b_irq_n` are 1 after that edge, whatever accesses are present.
- R2: A port A write cycle (`a_ce_n`=0, `a_rnw`=0; `a_oe_n` ignored) with `a_addr`=0x1FFF drives `b_irq_n` to 0 from the next clock.
- R3: A port B read cycle (`b_ce_n`=0, `b_oe_n`=0, `b_rnw`=1) with `b_addr`=0x1FFF drives `b_irq_n` to 1 from the next clock, unless R8 applies.
- R4: A port B write cycle (`b_ce_n`=0, `b_rnw`=0) with `b_addr`=0x1FFE drives `a_irq_n` to 0 from the next clock.
- R5: A port A read cycle (`a_ce_n`=0, `a_oe_n`=0, `a_rnw`=1) with `a_addr`=0x1FFE drives `a_irq_n` to 1 from the next clock, unless R8 applies.
- R6: A read with `*_oe_n`=1 is not a read, so it does not clear a flag.
- R7: An access with `*_ce_n`=1 is ignored. It neither sets nor clears a flag.
- R8: When a flag is set and cleared in the same cycle, the set wins and the flag is 0 after that edge.
- R9: A flag holds its value in every cycle without a set or clear event for it. A port's accesses to other addresses, a port's own reads of the opposite mailbox, and a port's writes to its own mailbox have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_ce_n | input | 1 | Port A chip enable, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_rnw | input | 1 | Port A strobe: 1 read, 0 write |
| a_addr | input | 13 | Port A word address |
| b_ce_n | input | 1 | Port B chip enable, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_rnw | input | 1 | Port B strobe: 1 read, 0 write |
| b_addr | input | 13 | Port B word address |
| a_irq_n | output | 1 | Port A interrupt flag, active low |
| b_irq_n | output | 1 | Port B interrupt flag, active low |

## Verification
The bench sets a flag and a clear of the same flag in one cycle. A design that gives the clear priority would lose the message and return the flag high. It checks that a port reading the opposite mailbox, writing its own mailbox, or reading the right mailbox with output enable high leaves the flags alone. A decoder that ignores the port, the direction or the output enable would clear or raise the wrong flag. It also applies accesses with chip enable high and reset asserted together with a mailbox write. A design that lets either of these through would show a flag low where it should be high.

// File: rtl/mbx_pkg.sv
// Package: shared constants and the access classification used by every
// mailbox port decoder. Assumes active-low enables and a read-high strobe.
package mbx_pkg;

    localparam int unsigned MBX_PORTS = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // Classify one port's control lines for the current cycle.
    function automatic acc_kind_e classify(input logic ce_n, input logic oe_n,
                                           input logic rnw);
        acc_kind_e k;
        k = ACC_NONE;
        if (!ce_n) begin
            if (!rnw)      k = ACC_WRITE;
            else if (!oe_n) k = ACC_READ;
        end
        return k;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
// Module: mbx_port_decode
// Decodes one memory port into two strobes: a read of the mailbox this port
// owns (clears its own flag) and a write of the peer's mailbox (sets the
// peer flag). Purely combinational; assumes inputs are stable around the edge.
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int unsigned          ADDR_W  = 13,
    parameter logic [ADDR_W-1:0]    OWN_MBX = '1,
    parameter logic [ADDR_W-1:0]    PEER_MBX = '1
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    output logic              own_rd_hit,
    output logic              peer_wr_hit
);

    acc_kind_e kind;

    // Turn the control lines into a cycle type, then match the address.
    always_comb begin
        kind        = classify(ce_n, oe_n, rnw);
        own_rd_hit  = (kind == ACC_READ)  && (addr == OWN_MBX);
        peer_wr_hit = (kind == ACC_WRITE) && (addr == PEER_MBX);
    end

endmodule

// File: rtl/mbx_irq_flag.sv
// Module: mbx_irq_flag
// One active-low interrupt flag. A set request drives it low, a clear
// request drives it high, and a set in the same cycle as a clear wins.
// Assumes a synchronous active-low reset that returns it to the idle level.
module mbx_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);

    // Flag register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_n_o <= 1'b1;
        else if (set_i)  irq_n_o <= 1'b0;
        else if (clr_i)  irq_n_o <= 1'b1;
    end

endmodule

// File: rtl/dpram_mailbox_irq.sv
// Module: dpram_mailbox_irq
// Mailbox interrupt logic for a two-port memory. Port A writes the top word
// to interrupt port B, and port B writes the word below it to interrupt
// port A. Each receiver clears its flag by reading its mailbox. The data word
// is held in the memory array outside this block. Port index 0 is A, 1 is B.
module dpram_mailbox_irq
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_ce_n,
    input  logic              a_oe_n,
    input  logic              a_rnw,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_ce_n,
    input  logic              b_oe_n,
    input  logic              b_rnw,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_irq_n,
    output logic              b_irq_n
);

    localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;
    localparam logic [ADDR_W-1:0] NEXT_ADDR = TOP_ADDR - ADDR_W'(1);

    logic [MBX_PORTS-1:0] ce_n_v, oe_n_v, rnw_v;
    logic [ADDR_W-1:0]    addr_v [MBX_PORTS];
    logic [MBX_PORTS-1:0] rd_hit_v, wr_hit_v, irq_n_v;

    // Gather the two named ports into indexable vectors.
    always_comb begin
        ce_n_v    = {b_ce_n, a_ce_n};
        oe_n_v    = {b_oe_n, a_oe_n};
        rnw_v     = {b_rnw,  a_rnw};
        addr_v[0] = a_addr;
        addr_v[1] = b_addr;
    end

    for (genvar p = 0; p < MBX_PORTS; p++) begin : g_port
        // Port p owns NEXT_ADDR + p and writes to TOP_ADDR - p.
        localparam logic [ADDR_W-1:0] OWN  = NEXT_ADDR + ADDR_W'(p);
        localparam logic [ADDR_W-1:0] PEER = TOP_ADDR - ADDR_W'(p);

        mbx_port_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_MBX (OWN),
            .PEER_MBX(PEER)
        ) u_dec (
            .ce_n       (ce_n_v[p]),
            .oe_n       (oe_n_v[p]),
            .rnw        (rnw_v[p]),
            .addr       (addr_v[p]),
            .own_rd_hit (rd_hit_v[p]),
            .peer_wr_hit(wr_hit_v[p])
        );

        mbx_irq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (wr_hit_v[MBX_PORTS-1-p]),
            .clr_i  (rd_hit_v[p]),
            .irq_n_o(irq_n_v[p])
        );
    end

    assign a_irq_n = irq_n_v[0];
    assign b_irq_n = irq_n_v[1];

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (a_irq_n && b_irq_n));

    // R2
    a_sends_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_ce_n && !a_rnw && a_addr == TOP_ADDR) |=> !b_irq_n);

    // R4
    b_sends_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_ce_n && !b_rnw && b_addr == NEXT_ADDR) |=> !a_irq_n);

    // R3
    b_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_ce_n && !b_oe_n && b_rnw && b_addr == TOP_ADDR &&
         !(!a_ce_n && !a_rnw && a_addr == TOP_ADDR)) |=> b_irq_n);

    // R5
    a_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_ce_n && !a_oe_n && a_rnw && a_addr == NEXT_ADDR &&
         !(!b_ce_n && !b_rnw && b_addr == NEXT_ADDR)) |=> a_irq_n);

    // R9
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!a_ce_n && !a_rnw && a_addr == TOP_ADDR) &&
         !(!b_ce_n && !b_oe_n && b_rnw && b_addr == TOP_ADDR))
        |=> $stable(b_irq_n));

    // R9
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!b_ce_n && !b_rnw && b_addr == NEXT_ADDR) &&
         !(!a_ce_n && !a_oe_n && a_rnw && a_addr == NEXT_ADDR))
        |=> $stable(a_irq_n));

    // R8
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_ce_n && !a_rnw && a_addr == TOP_ADDR &&
         !b_ce_n && !b_oe_n && b_rnw && b_addr == TOP_ADDR) |=> !b_irq_n);

endmodule

// File: tb/dpram_mailbox_irq_tb_top.sv
// Bench: scoreboard style. The driver applies one access pair per cycle at
// the falling edge and queues the expected flags from a requirement model.
// The monitor pops one item after each rising edge and compares.
module dpram_mailbox_irq_tb_top;

    localparam int unsigned AW = 13;
    localparam logic [AW-1:0] MB_HI = 13'h1FFF;
    localparam logic [AW-1:0] MB_LO = 13'h1FFE;

    typedef struct {
        logic  exp_a;
        logic  exp_b;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_ce_n = 1'b1, a_oe_n = 1'b1, a_rnw = 1'b1;
    logic b_ce_n = 1'b1, b_oe_n = 1'b1, b_rnw = 1'b1;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic a_irq_n, b_irq_n;

    item_t sb_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    logic  done = 1'b0;
    logic  m_a = 1'b1, m_b = 1'b1;

    always #4 clk = ~clk;

    dpram_mailbox_irq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_ce_n(a_ce_n), .a_oe_n(a_oe_n), .a_rnw(a_rnw), .a_addr(a_addr),
        .b_ce_n(b_ce_n), .b_oe_n(b_oe_n), .b_rnw(b_rnw), .b_addr(b_addr),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    // Driver: apply one cycle and queue what the requirements predict.
    task automatic step(input logic rst, input logic ace, input logic aoe,
                        input logic arnw, input logic [AW-1:0] aad,
                        input logic bce, input logic boe, input logic brnw,
                        input logic [AW-1:0] bad, input string tag);
        item_t it;
        logic set_a, clr_a, set_b, clr_b;
        @(negedge clk);
        rst_n = rst;
        a_ce_n = ace; a_oe_n = aoe; a_rnw = arnw; a_addr = aad;
        b_ce_n = bce; b_oe_n = boe; b_rnw = brnw; b_addr = bad;
        set_b = !ace && !arnw && aad == MB_HI;
        clr_b = !bce && !boe && brnw && bad == MB_HI;
        set_a = !bce && !brnw && bad == MB_LO;
        clr_a = !ace && !aoe && arnw && aad == MB_LO;
        if (!rst) begin
            m_a = 1'b1; m_b = 1'b1;
        end else begin
            if (set_a) m_a = 1'b0; else if (clr_a) m_a = 1'b1;
            if (set_b) m_b = 1'b0; else if (clr_b) m_b = 1'b1;
        end
        it.exp_a = m_a;
        it.exp_b = m_b;
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare one queued item shortly after every rising edge.
    initial forever begin
        @(posedge clk);
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (a_irq_n !== it.exp_a || b_irq_n !== it.exp_b) begin
                n_bad++;
                $display("FAIL %s: actual a_irq_n=%b b_irq_n=%b expected a_irq_n=%b b_irq_n=%b",
                         it.tag, a_irq_n, b_irq_n, it.exp_a, it.exp_b);
            end
        end
    end

    // Stimulus sequence.
    initial begin
        step(0, 0,1,0,MB_HI, 0,1,0,MB_LO, "R1 reset with writes");
        step(0, 1,1,1,'0,    1,1,1,'0,    "R1 reset idle");
        step(1, 1,1,1,'0,    1,1,1,'0,    "R9 idle");
        step(1, 0,1,0,MB_HI, 1,1,1,'0,    "R2 A writes B mailbox");
        step(1, 1,1,1,'0,    1,1,1,'0,    "R9 hold low");
        step(1, 0,0,1,MB_HI, 1,1,1,'0,    "R9 A reads B mailbox");
        step(1, 1,1,1,'0,    0,1,1,MB_HI, "R6 B read without oe");
        step(1, 1,1,1,'0,    1,0,1,MB_HI, "R7 B read without ce");
        step(1, 1,1,1,'0,    0,0,1,MB_HI, "R3 B reads its mailbox");
        step(1, 1,1,1,'0,    0,1,0,MB_LO, "R4 B writes A mailbox");
        step(1, 1,1,1,'0,    0,0,0,MB_LO, "R4 B write oe low still write");
        step(1, 0,1,1,MB_LO, 1,1,1,'0,    "R6 A read without oe");
        step(1, 0,0,1,13'h1FFD, 1,1,1,'0, "R9 A reads other address");
        step(1, 0,0,1,MB_LO, 1,1,1,'0,    "R5 A reads its mailbox");
        step(1, 0,1,0,MB_LO, 1,1,1,'0,    "R9 A writes own mailbox");
        step(1, 1,1,1,'0,    0,1,0,MB_HI, "R9 B writes own mailbox");
        step(1, 1,1,1,'0,    1,1,0,MB_LO, "R7 B write without ce");
        step(1, 0,1,0,MB_HI, 0,0,1,MB_HI, "R8 set and clear B same cycle");
        step(1, 0,1,0,MB_HI, 0,0,1,MB_HI, "R8 set and clear B again");
        step(1, 0,0,1,MB_LO, 0,1,0,MB_LO, "R8 set and clear A same cycle");
        step(1, 0,0,1,MB_LO, 0,0,1,MB_HI, "R3 R5 both clear");
        step(1, 0,0,0,MB_HI, 0,1,0,MB_LO, "R2 R4 both set, oe low");
        step(0, 1,1,1,'0,    1,1,1,'0,    "R1 reset mid-run");
        step(1, 1,1,1,'0,    1,1,1,'0,    "R9 idle after reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(8 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual run still going, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule